// File: doc/BRIEF.md
# Dual Down-Counting Timer Peripheral

This block contains two independent down-counters. Software reaches them through a small word-addressed register port. A single control word holds each channel's settings: run enable, automatic reload, a choice of time base and a power-of-two divider. A single status word holds one expiry flag per channel. Each channel also has a reload register and a live count register. Writing the live count register starts a fresh countdown straight away, without changing the reload register.

Each channel counts from one of two time bases. The first is the core clock. The second is an external strobe, `ref_tick_i`, which pulses once per period of a slower reference. The chosen time base is divided by 2^k, where k is the channel's divider field. On each divided tick an enabled counter decrements by one. When the counter is already at zero, the tick raises the channel's expiry flag instead. After that a periodic channel reloads and keeps running, while a one-shot channel stops at zero and clears its own enable bit.

Software counts elapsed time by inverting the live count. Software clears an expiry flag by writing a 0 to its bit position. The interrupt output follows channel 1's flag.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Byte offsets are: 0x00 control, 0x04 status, 0x10 and 0x14 channel 0 reload and count, 0x18 and 0x1C channel 1 reload and count. Read data appears on `rdata_o` in the cycle after `rd_en_i`. Any other offset, including an unaligned one, reads zero and ignores writes.
- R3: Control bit positions are: channel 0 enable 0, reload 1, base select 11, divider 21:19. Channel 1 enable 2, reload 3, base select 12, divider 24:22. Control readback returns these bits and zero elsewhere.
- R4: Each divided tick on an enabled, nonzero counter lowers it by exactly one. Writing the count register loads the counter directly and leaves the reload register unchanged.
- R5: One-shot (reload bit 0): a tick at zero sets the flag, the count stays at zero and the channel's enable bit reads back 0.
- R6: Periodic (reload bit 1): a tick at zero sets the flag and loads the reload value, and the enable stays set. The period is reload+1 ticks.
- R7: With base select 1 the counter advances only on `ref_tick_i` strobes. With base select 0 it uses every core cycle.
- R8: With the core clock, a one-shot count N and divider k, the flag is set (N+1)*2^k cycles after the edge that wrote the enable.
- R9: Status bit 0 is channel 0's flag and bit 8 is channel 1's. Writing 0 to a flag's bit clears it, and writing 1 leaves it unchanged.
- R10: When an expiry and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R11: `irq_o` is high exactly while channel 1's flag is set. Channel 0's flag never raises it.
- R12: A disabled counter holds its value. Clearing the enable restarts the divider phase, so after re-enabling, the first tick needs a full 2^k base events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle strobe per reference period |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Channel 1 expiry interrupt |

## Verification
A divider phase that is off by one moves the expiry edge by whole multiples of 2^k cycles. The core-clock interval count exposes this at `irq_o` within one period. A wrong count state, or a reload that does not happen, shows up at the next read of the count register or at the next expected flag. Driving the time base from the reference strobe makes every count deterministic at the moment it is read. A wrong enable or flag update, such as a lost self-disable or a clear that beats the set, is visible in the very next control or status read.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

   localparam int NUM_CH = 2;
   localparam int DIV_PITCH = 3;
   localparam int DATA_W = 32;

   localparam int OFS_CTRL = 'h00;
   localparam int OFS_STAT = 'h04;

   function automatic int rld_ofs(input int ch);
      return 'h10 + 8 * ch;
   endfunction

   function automatic int val_ofs(input int ch);
      return 'h14 + 8 * ch;
   endfunction

   function automatic int en_bit(input int ch);
      return 2 * ch;
   endfunction

   function automatic int auto_bit(input int ch);
      return 2 * ch + 1;
   endfunction

   function automatic int sel_bit(input int ch);
      return 11 + ch;
   endfunction

   function automatic int div_lsb(input int ch);
      return 19 + DIV_PITCH * ch;
   endfunction

   function automatic int flag_bit(input int ch);
      return 8 * ch;
   endfunction

endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
   parameter int DIV_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             ref_sel_i,
   input  logic             ref_tick_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   localparam int PS_W = (1 << DIV_W) - 1;

   logic            base_en;
   logic [PS_W-1:0] phase_q;
   logic [PS_W-1:0] mask;

   assign base_en = ref_sel_i ? ref_tick_i : 1'b1;

   always_comb begin
      mask = PS_W'((1 << div_i) - 1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= '0;
      end else if (!en_i) begin
         phase_q <= '0;
      end else if (base_en) begin
         phase_q <= phase_q + 1'b1;
      end
   end

   assign tick_o = en_i & base_en & ((phase_q & mask) == mask);

   // R8
   no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_i != '0 && $stable(div_i) && $past(en_i)) |-> !(tick_o && $past(tick_o)));

endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             auto_i,
   input  logic             tick_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   input  logic [CNT_W-1:0] rld_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   logic at_zero;

   assign at_zero  = (count_o == '0);
   assign expire_o = en_i & tick_i & at_zero & ~ld_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_o <= '0;
      end else if (ld_i) begin
         count_o <= ld_val_i;
      end else if (en_i && tick_i) begin
         if (!at_zero) begin
            count_o <= count_o - 1'b1;
         end else if (auto_i) begin
            count_o <= rld_val_i;
         end
      end
   end

   // R12
   hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !ld_i) |=> $stable(count_o));

   // R4
   load_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i |=> (count_o == $past(ld_val_i)));

   // R5
   oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_o && !auto_i) |=> (count_o == '0));

   // R6
   periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_o && auto_i) |=> (count_o == $past(rld_val_i)));

endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
   import dtmr_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int CNT_W     = 32,
   parameter int DIV_W     = 3,
   parameter bit READ_FLOP = 1'b1
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [DATA_W-1:0]             wdata_i,
   input  logic                          wr_i,
   input  logic                          rd_i,
   output logic [DATA_W-1:0]             rdata_o,
   input  logic [NUM_CH-1:0]             expire_i,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  count_i,
   output logic [NUM_CH-1:0]             en_o,
   output logic [NUM_CH-1:0]             auto_o,
   output logic [NUM_CH-1:0]             sel_o,
   output logic [NUM_CH-1:0][DIV_W-1:0]  div_o,
   output logic [NUM_CH-1:0][CNT_W-1:0]  rld_o,
   output logic [NUM_CH-1:0]             ld_o,
   output logic [NUM_CH-1:0]             flag_o
);

   logic              hit_ctrl;
   logic              hit_stat;
   logic [DATA_W-1:0] rd_mux;

   assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
   assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int EN_B   = en_bit(c);
      localparam int AUTO_B = auto_bit(c);
      localparam int SEL_B  = sel_bit(c);
      localparam int DIV_B  = div_lsb(c);
      localparam int FLAG_B = flag_bit(c);

      logic hit_rld;
      logic hit_val;
      logic ctrl_wr;
      logic stat_wr;

      assign hit_rld = (addr_i == ADDR_W'(rld_ofs(c)));
      assign hit_val = (addr_i == ADDR_W'(val_ofs(c)));
      assign ctrl_wr = wr_i & hit_ctrl;
      assign stat_wr = wr_i & hit_stat;
      assign ld_o[c] = wr_i & hit_val;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rld_o[c] <= '0;
         end else if (wr_i && hit_rld) begin
            rld_o[c] <= wdata_i[CNT_W-1:0];
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            auto_o[c] <= 1'b0;
            sel_o[c]  <= 1'b0;
            div_o[c]  <= '0;
         end else if (ctrl_wr) begin
            auto_o[c] <= wdata_i[AUTO_B];
            sel_o[c]  <= wdata_i[SEL_B];
            div_o[c]  <= wdata_i[DIV_B +: DIV_W];
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_o[c] <= 1'b0;
         end else if (ctrl_wr) begin
            en_o[c] <= wdata_i[EN_B];
         end else if (expire_i[c] && !auto_o[c]) begin
            en_o[c] <= 1'b0;
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            flag_o[c] <= 1'b0;
         end else if (expire_i[c]) begin
            flag_o[c] <= 1'b1;
         end else if (stat_wr && !wdata_i[FLAG_B]) begin
            flag_o[c] <= 1'b0;
         end
      end

      // R10
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         expire_i[c] |=> flag_o[c]);

      // R9
      zero_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (stat_wr && !wdata_i[FLAG_B] && !expire_i[c]) |=> !flag_o[c]);

      // R9
      one_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (stat_wr && wdata_i[FLAG_B] && flag_o[c]) |=> flag_o[c]);

      // R5
      self_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (expire_i[c] && !auto_o[c] && !ctrl_wr) |=> !en_o[c]);
   end

   always_comb begin
      rd_mux = '0;
      if (hit_ctrl) begin
         for (int c = 0; c < NUM_CH; c++) begin
            rd_mux[en_bit(c)]            = en_o[c];
            rd_mux[auto_bit(c)]          = auto_o[c];
            rd_mux[sel_bit(c)]           = sel_o[c];
            rd_mux[div_lsb(c) +: DIV_W]  = div_o[c];
         end
      end else if (hit_stat) begin
         for (int c = 0; c < NUM_CH; c++) begin
            rd_mux[flag_bit(c)] = flag_o[c];
         end
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (addr_i == ADDR_W'(rld_ofs(c))) begin
               rd_mux = DATA_W'(rld_o[c]);
            end
            if (addr_i == ADDR_W'(val_ofs(c))) begin
               rd_mux = DATA_W'(count_i[c]);
            end
         end
      end
   end

   if (READ_FLOP) begin : g_rd_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rdata_o <= '0;
         end else begin
            rdata_o <= rd_i ? rd_mux : '0;
         end
      end
   end else begin : g_rd_comb
      assign rdata_o = rd_i ? rd_mux : '0;
   end

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
   import dtmr_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int CNT_W     = 32,
   parameter int DIV_W     = 3,
   parameter bit READ_FLOP = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ref_tick_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   output logic [31:0]       rdata_o,
   output logic              irq_o
);

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie between 2 and 32");
   end
   if (DIV_W < 1 || DIV_W > DIV_PITCH) begin : g_bad_div
      $error("DIV_W must lie between 1 and 3");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end

   logic [NUM_CH-1:0]            en;
   logic [NUM_CH-1:0]            auto_rl;
   logic [NUM_CH-1:0]            sel;
   logic [NUM_CH-1:0][DIV_W-1:0] div;
   logic [NUM_CH-1:0][CNT_W-1:0] rld;
   logic [NUM_CH-1:0][CNT_W-1:0] count;
   logic [NUM_CH-1:0]            ld;
   logic [NUM_CH-1:0]            expire;
   logic [NUM_CH-1:0]            tick;
   logic [NUM_CH-1:0]            flag;

   dtmr_regs #(
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .DIV_W    (DIV_W),
      .READ_FLOP(READ_FLOP)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .wr_i    (wr_en_i),
      .rd_i    (rd_en_i),
      .rdata_o (rdata_o),
      .expire_i(expire),
      .count_i (count),
      .en_o    (en),
      .auto_o  (auto_rl),
      .sel_o   (sel),
      .div_o   (div),
      .rld_o   (rld),
      .ld_o    (ld),
      .flag_o  (flag)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      dtmr_prescaler #(
         .DIV_W(DIV_W)
      ) u_pre (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .en_i      (en[c]),
         .ref_sel_i (sel[c]),
         .ref_tick_i(ref_tick_i),
         .div_i     (div[c]),
         .tick_o    (tick[c])
      );

      dtmr_counter #(
         .CNT_W(CNT_W)
      ) u_cnt (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .en_i     (en[c]),
         .auto_i   (auto_rl[c]),
         .tick_i   (tick[c]),
         .ld_i     (ld[c]),
         .ld_val_i (wdata_i[CNT_W-1:0]),
         .rld_val_i(rld[c]),
         .count_o  (count[c]),
         .expire_o (expire[c])
      );
   end

   assign irq_o = flag[1];

   // R11
   irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(expire[1]));

   // R7
   ref_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel[0] && !ref_tick_i && !ld[0]) |=> $stable(count[0]));

endmodule

// File: tb/tb_dual_down_timer.sv
`timescale 1ns/1ps
module tb_dual_down_timer;

   localparam logic [4:0] A_CTRL = 5'h00;
   localparam logic [4:0] A_STAT = 5'h04;
   localparam logic [4:0] A_RLD0 = 5'h10;
   localparam logic [4:0] A_VAL0 = 5'h14;
   localparam logic [4:0] A_RLD1 = 5'h18;
   localparam logic [4:0] A_VAL1 = 5'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [31:0] rdata;
   logic        irq;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   rd_item_t sb_q[$];
   int       total = 0;
   int       bad = 0;
   logic     rd_vld = 1'b0;

   always #2.5 clk = ~clk;

   dual_down_timer dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .ref_tick_i(ref_tick),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .wr_en_i   (wr),
      .rd_en_i   (rd),
      .rdata_o   (rdata),
      .irq_o     (irq)
   );

   always @(posedge clk) rd_vld <= rd;

   // monitor: compare each returned read word against the scoreboard
   always @(negedge clk) begin
      rd_item_t it;
      if (rd_vld) begin
         total++;
         if (sb_q.size() == 0) begin
            bad++;
            $display("FAIL R2: unexpected read data %h, expected none", rdata);
         end else begin
            it = sb_q.pop_front();
            if (rdata !== it.exp) begin
               bad++;
               $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input bit with_ref = 1'b0);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1; ref_tick = with_ref;
      @(negedge clk);
      wr = 1'b0; ref_tick = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
      sb_q.push_back('{exp: e, tag: tag});
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
      end
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   initial begin
      #(5.0 * 100000);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(irq === 1'b0, "R1 irq", 32'(irq), 32'h0);
      bus_rd(A_CTRL, 32'h0, "R1 ctrl");
      bus_rd(A_STAT, 32'h0, "R1 stat");
      bus_rd(A_RLD0, 32'h0, "R1 rld0");
      bus_rd(A_VAL0, 32'h0, "R1 val0");
      bus_rd(A_RLD1, 32'h0, "R1 rld1");
      bus_rd(A_VAL1, 32'h0, "R1 val1");

      // R3 control field readback, enables off
      bus_wr(A_CTRL, 32'hFFFF_FFFA);
      bus_rd(A_CTRL, 32'h01F8_180A, "R3 ctrl fields");
      bus_wr(A_CTRL, 32'h0);
      // R2 map, undefined and unaligned offsets
      bus_wr(A_RLD0, 32'hDEAD_BEEF);
      bus_wr(A_RLD1, 32'h1234_5678);
      bus_rd(A_RLD0, 32'hDEAD_BEEF, "R2 rld0");
      bus_rd(A_RLD1, 32'h1234_5678, "R2 rld1");
      bus_wr(5'h08, 32'hFFFF_FFFF);
      bus_wr(5'h11, 32'h0);
      bus_rd(5'h08, 32'h0, "R2 hole 08");
      bus_rd(5'h0C, 32'h0, "R2 hole 0C");
      bus_rd(5'h01, 32'h0, "R2 unaligned");
      bus_rd(A_RLD0, 32'hDEAD_BEEF, "R2 unaligned write ignored");

      // R7 / R4 channel 0 on reference strobes, one-shot
      bus_wr(A_VAL0, 32'd5);
      bus_wr(A_CTRL, 32'h0000_0801);
      bus_rd(A_VAL0, 32'd5, "R7 no strobe no count");
      pulse(3);
      bus_rd(A_VAL0, 32'd2, "R4 decrement per tick");
      bus_rd(A_RLD0, 32'hDEAD_BEEF, "R4 reload untouched");
      pulse(2);
      bus_rd(A_VAL0, 32'd0, "R4 reached zero");
      bus_rd(A_STAT, 32'h0, "R5 no flag at zero");
      pulse(1);
      bus_rd(A_STAT, 32'h1, "R5 flag on expiry");
      bus_rd(A_CTRL, 32'h0000_0800, "R5 self disable");
      chk(irq === 1'b0, "R11 ch0 flag no irq", 32'(irq), 32'h0);
      pulse(1);
      bus_rd(A_VAL0, 32'd0, "R12 held when off");

      // R9 clearing rules
      bus_wr(A_STAT, 32'hFFFF_FFFF);
      bus_rd(A_STAT, 32'h1, "R9 write one keeps");
      bus_wr(A_STAT, 32'hFFFF_FFFE);
      bus_rd(A_STAT, 32'h0, "R9 write zero clears");

      // R6 channel 1 periodic, R11 irq
      bus_wr(A_RLD1, 32'd2);
      bus_wr(A_VAL1, 32'd2);
      bus_wr(A_CTRL, 32'h0000_100C);
      pulse(2);
      bus_rd(A_VAL1, 32'd0, "R6 countdown");
      chk(irq === 1'b0, "R11 irq low before expiry", 32'(irq), 32'h0);
      pulse(1);
      chk(irq === 1'b1, "R11 irq on ch1 flag", 32'(irq), 32'h1);
      bus_rd(A_STAT, 32'h100, "R9 ch1 flag bit 8");
      bus_rd(A_VAL1, 32'd2, "R6 reloaded");
      bus_rd(A_CTRL, 32'h0000_100C, "R6 stays enabled");
      bus_wr(A_STAT, 32'h0);
      chk(irq === 1'b0, "R11 irq follows clear", 32'(irq), 32'h0);
      pulse(2);
      bus_rd(A_STAT, 32'h0, "R6 no early expiry");
      pulse(1);
      bus_rd(A_STAT, 32'h100, "R6 period reload+1");

      // R10 set beats clear
      bus_wr(A_CTRL, 32'h0);
      bus_wr(A_STAT, 32'h0);
      bus_wr(A_VAL0, 32'd0);
      bus_wr(A_CTRL, 32'h0000_0801);
      bus_wr(A_STAT, 32'h0, 1'b1);
      bus_rd(A_STAT, 32'h1, "R10 set wins");
      bus_rd(A_CTRL, 32'h0000_0800, "R5 self disable again");
      bus_wr(A_STAT, 32'h0);

      // R12 divider restart, divider 1 on reference strobes
      bus_wr(A_VAL0, 32'd10);
      bus_wr(A_CTRL, 32'h0008_0801);
      pulse(1);
      bus_rd(A_VAL0, 32'd10, "R12 half period");
      bus_wr(A_CTRL, 32'h0008_0800);
      pulse(2);
      bus_rd(A_VAL0, 32'd10, "R12 held when off");
      bus_wr(A_CTRL, 32'h0008_0801);
      pulse(1);
      bus_rd(A_VAL0, 32'd10, "R12 phase restarted");
      pulse(1);
      bus_rd(A_VAL0, 32'd9, "R12 full period tick");

      // R8 core clock, N=3, k=2 -> 16 cycles
      bus_wr(A_CTRL, 32'h0);
      bus_wr(A_STAT, 32'h0);
      bus_wr(A_VAL1, 32'd3);
      bus_wr(A_CTRL, 32'h0080_0004);
      cyc = 0;
      while (irq !== 1'b1 && cyc < 1000) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc == 16, "R8 expiry interval", 32'(cyc), 32'd16);
      bus_rd(A_VAL1, 32'd0, "R8 count at zero");
      bus_rd(A_CTRL, 32'h0080_0000, "R8 one-shot disabled");

      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R2 all reads returned", 32'(sb_q.size()), 32'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule